// File: doc/BRIEF.md
# Configuration ROM and Control/Status Space with Slot Addressing

This block serves the configuration space of a VME64x slave card. The bus front end presents one access per request strobe, with the address modifier, a 24-bit byte address, a write flag and a data byte. The block decides whether the access falls in its own page. It answers one cycle later with a response strobe, an acknowledge flag and, for reads, the data byte.

The page is not set by switches. It comes from the five geographic-address pins of the slot and their parity pin. When the pins carry a valid code, the page base is the slot number placed in address bits 23 to 19. A parity error, an all-ones code (a crate with no slot pins, pulled high) or a zero code is treated as a fault. In that case the base reads as zero and the space never answers.

Inside the page there are several kinds of location. A low window holds constant configuration-ROM bytes. The set and clear registers hold the module-enable and module-reset controls. Two plain byte registers hold the interrupt level and the interrupt vector. The module-enable output gates the card's data-space decoders, which are outside this block. The module-reset output drives the reset of the local logic.

The access sequencer has four states, and each response state lasts exactly one cycle:
- IDLE: no response. A request moves it to RD_RESP (read hit), WR_RESP (write hit) or MISS (no hit).
- RD_RESP, WR_RESP and MISS: the response cycle. A new request in this cycle is decoded in the same way. With no request it returns to IDLE.

Top module: `crcsr_space`

## Requirements
- R1: An access hits only when the address modifier is 0x2F, the slot code is valid and address bits 23:19 equal the slot code. Any other access gets a response with the acknowledge flag low and changes no register.
- R2: The slot code is valid only when the five slot pins plus the parity pin hold an odd number of ones and the slot code is neither 0 nor 31. When the code is invalid, base_ok is 0, base_addr is 0 and module_en is 0.
- R3: Every request is answered by rsp_valid high in the cycle after the request, and only then. rsp_ack is high in that cycle exactly for hits.
- R4: Read data appears on rdata in the response cycle. Reads of unimplemented offsets return 0x00.
- R5: A write to the set register (offset 0x7fffb) with bit 4 set turns module_en on. A write to the clear register (offset 0x7fff7) with bit 4 set turns it off. Reads of either register return the current bits: bit 7 is reset and bit 4 is enable, all other bits 0.
- R6: A write to the set register with bit 7 set raises local_rst. Any later write hit clears local_rst, unless that write is itself a set-register write with bit 7 set. Read hits leave it unchanged.
- R7: The interrupt vector register (offset 0x7ff5f) and the interrupt level register (offset 0x7ff5b) are both reset to 0x00. Each takes a written byte and drives it on irq_vector or irq_level.
- R8: Offsets 0x00000 to 0x00fff return ROM bytes, and writes there are ignored. Offset 0x01f returns 0x43 and offset 0x023 returns 0x52. Any other offset with bits 1:0 equal to 3 returns offset[9:2] XOR 0xA5. All other offsets return 0x00.
- R9: After reset, rsp_valid, rsp_ack, module_en and local_rst are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_ga | input | 5 | Slot geographic code (active high) |
| slot_gap | input | 1 | Slot parity pin |
| req | input | 1 | Access request strobe, one cycle |
| we | input | 1 | 1 for write, 0 for read |
| am | input | 6 | Address modifier |
| addr | input | 24 | Byte address |
| wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_ack | output | 1 | Response is a hit |
| rdata | output | 8 | Read data |
| base_ok | output | 1 | Slot code is valid |
| base_addr | output | 5 | Page base (address bits 23:19) |
| module_en | output | 1 | Data-space decoders may respond |
| local_rst | output | 1 | Reset to the local logic |
| irq_level | output | 8 | Interrupt level register |
| irq_vector | output | 8 | Interrupt vector register |

## Verification
The bench checks the self-clearing reset bit in three ways. A read must leave it set, a write elsewhere must clear it, and a design that cleared it on any access, or never cleared it, would be caught. It uses a wrong address modifier and a neighbouring slot's page, each carrying a write. A decoder that ignored either field would ack that access and alter the vector register. It covers a flipped parity pin and the all-ones pull-up code. A parity test of the wrong sense, or a missing pull-up check, would leave the page reachable and module_en high. It also writes into the ROM window and reads back the computed bytes, which catches a ROM that stores data or a wrong byte lane.

// File: rtl/crcsr_pkg.sv
package crcsr_pkg;
    localparam int GA_W   = 5;
    localparam int ADDR_W = 24;
    localparam int OFF_W  = ADDR_W - GA_W;
    localparam int DATA_W = 8;

    localparam logic [5:0]       AM_CFG     = 6'h2F;
    localparam logic [OFF_W-1:0] OFF_SET    = 19'h7fffb;
    localparam logic [OFF_W-1:0] OFF_CLR    = 19'h7fff7;
    localparam logic [OFF_W-1:0] OFF_VECTOR = 19'h7ff5f;
    localparam logic [OFF_W-1:0] OFF_LEVEL  = 19'h7ff5b;
    localparam logic [OFF_W-1:0] ROM_LAST   = 19'h00fff;

    localparam int BIT_RST = 7;
    localparam int BIT_EN  = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_WR_RESP = 2'd2,
        ST_MISS    = 2'd3
    } acc_state_t;
endpackage

// File: rtl/crcsr_geo.sv
module crcsr_geo
    import crcsr_pkg::*;
(
    input  logic [GA_W-1:0] slot_ga,
    input  logic            slot_gap,
    output logic            code_ok,
    output logic [GA_W-1:0] base
);
    localparam logic [GA_W-1:0] ALL_ONES = '1;

    logic parity_odd;

    always_comb begin
        parity_odd = ^{slot_ga, slot_gap};
        code_ok    = parity_odd && (slot_ga != ALL_ONES) && (slot_ga != '0);
        base       = code_ok ? slot_ga : '0;
    end
endmodule

// File: rtl/crcsr_rom.sv
module crcsr_rom
    import crcsr_pkg::*;
#(
    parameter logic [DATA_W-1:0] ROM_SEED   = 8'hA5,
    parameter bit                ROM_SIG_EN = 1'b1
) (
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] byte_o
);
    logic [DATA_W-1:0] pattern;

    always_comb begin
        pattern = (off[1:0] == 2'b11) ? (off[9:2] ^ ROM_SEED) : '0;
    end

    generate
        if (ROM_SIG_EN) begin : g_sig
            always_comb begin
                if (off == 19'h0001f)      byte_o = 8'h43;
                else if (off == 19'h00023) byte_o = 8'h52;
                else                       byte_o = pattern;
            end
        end else begin : g_nosig
            always_comb byte_o = pattern;
        end
    endgenerate
endmodule

// File: rtl/crcsr_regs.sv
module crcsr_regs
    import crcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rom_byte,
    output logic [DATA_W-1:0] rdata_q,
    output logic              en_bit,
    output logic              rst_bit,
    output logic [DATA_W-1:0] level_q,
    output logic [DATA_W-1:0] vector_q
);
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] rd_mux;
    logic              is_set;
    logic              is_clr;

    always_comb begin
        is_set    = (off == OFF_SET);
        is_clr    = (off == OFF_CLR);
        ctrl_view = '0;
        ctrl_view[BIT_RST] = rst_bit;
        ctrl_view[BIT_EN]  = en_bit;
        if (off <= ROM_LAST)           rd_mux = rom_byte;
        else if (is_set || is_clr)     rd_mux = ctrl_view;
        else if (off == OFF_VECTOR)    rd_mux = vector_q;
        else if (off == OFF_LEVEL)     rd_mux = level_q;
        else                           rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bit   <= 1'b0;
            rst_bit  <= 1'b0;
            level_q  <= '0;
            vector_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (wr_hit) begin
                rst_bit <= is_set && wdata[BIT_RST];
                if (is_set && wdata[BIT_EN]) en_bit <= 1'b1;
                else if (is_clr && wdata[BIT_EN]) en_bit <= 1'b0;
                if (off == OFF_VECTOR) vector_q <= wdata;
                if (off == OFF_LEVEL)  level_q  <= wdata;
            end
            if (rd_hit) rdata_q <= rd_mux;
            else        rdata_q <= '0;
        end
    end
endmodule

// File: rtl/crcsr_fsm.sv
module crcsr_fsm
    import crcsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    input  logic hit,
    output logic rsp_valid,
    output logic rsp_ack
);
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (req) begin
            if (!hit)    state_d = ST_MISS;
            else if (we) state_d = ST_WR_RESP;
            else         state_d = ST_RD_RESP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:    begin rsp_valid = 1'b0; rsp_ack = 1'b0; end
            ST_RD_RESP: begin rsp_valid = 1'b1; rsp_ack = 1'b1; end
            ST_WR_RESP: begin rsp_valid = 1'b1; rsp_ack = 1'b1; end
            ST_MISS:    begin rsp_valid = 1'b1; rsp_ack = 1'b0; end
            default:    begin rsp_valid = 1'b0; rsp_ack = 1'b0; end
        endcase
    end
endmodule

// File: rtl/crcsr_space.sv
module crcsr_space
    import crcsr_pkg::*;
#(
    parameter logic [DATA_W-1:0] ROM_SEED = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GA_W-1:0]   slot_ga,
    input  logic              slot_gap,
    input  logic              req,
    input  logic              we,
    input  logic [5:0]        am,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rsp_valid,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rdata,
    output logic              base_ok,
    output logic [GA_W-1:0]   base_addr,
    output logic              module_en,
    output logic              local_rst,
    output logic [DATA_W-1:0] irq_level,
    output logic [DATA_W-1:0] irq_vector
);
    logic              hit;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] rom_byte;
    logic              en_bit;

    crcsr_geo u_geo (
        .slot_ga  (slot_ga),
        .slot_gap (slot_gap),
        .code_ok  (base_ok),
        .base     (base_addr)
    );

    always_comb begin
        off = addr[OFF_W-1:0];
        hit = (am == AM_CFG) && base_ok && (addr[ADDR_W-1:OFF_W] == base_addr);
    end

    crcsr_rom #(.ROM_SEED(ROM_SEED), .ROM_SIG_EN(1'b1)) u_rom (
        .off    (off),
        .byte_o (rom_byte)
    );

    crcsr_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (req && hit && we),
        .rd_hit   (req && hit && !we),
        .off      (off),
        .wdata    (wdata),
        .rom_byte (rom_byte),
        .rdata_q  (rdata),
        .en_bit   (en_bit),
        .rst_bit  (local_rst),
        .level_q  (irq_level),
        .vector_q (irq_vector)
    );

    crcsr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .hit       (hit),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack)
    );

    assign module_en = en_bit && base_ok;
endmodule

// File: rtl/crcsr_space_chk.sv
module crcsr_space_chk
    import crcsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [GA_W-1:0]   slot_ga,
    input logic              slot_gap,
    input logic              req,
    input logic              we,
    input logic [5:0]        am,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rsp_valid,
    input logic              rsp_ack,
    input logic [DATA_W-1:0] rdata,
    input logic              base_ok,
    input logic [GA_W-1:0]   base_addr,
    input logic              module_en,
    input logic              local_rst,
    input logic [DATA_W-1:0] irq_level,
    input logic [DATA_W-1:0] irq_vector
);
    logic port_hit;
    assign port_hit = (am == AM_CFG) && base_ok && (addr[ADDR_W-1:OFF_W] == base_addr);

    a_r3_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
    a_r1_wrong_am_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && am != AM_CFG) |=> !rsp_ack);
    a_r1_miss_keeps_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !port_hit) |=> $stable(irq_vector) && $stable(irq_level));
    a_r2_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ok |-> (base_addr == '0) && !module_en);
    a_r6_reset_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && port_hit && addr[OFF_W-1:0] != OFF_SET) |=> !local_rst);
    a_r6_read_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> $stable(local_rst));
endmodule

bind crcsr_space crcsr_space_chk u_chk (
    .clk(clk), .rst_n(rst_n), .slot_ga(slot_ga), .slot_gap(slot_gap),
    .req(req), .we(we), .am(am), .addr(addr), .wdata(wdata),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rdata(rdata),
    .base_ok(base_ok), .base_addr(base_addr), .module_en(module_en),
    .local_rst(local_rst), .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/crcsr_space_tb.sv
module crcsr_space_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] slot_ga = 5'd3;
    logic       slot_gap = 1'b1;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [5:0] am = 6'h2F;
    logic [23:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rsp_valid, rsp_ack, base_ok, module_en, local_rst;
    logic [7:0] rdata, irq_level, irq_vector;
    logic [4:0] base_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    crcsr_space u_dut (
        .clk(clk), .rst_n(rst_n), .slot_ga(slot_ga), .slot_gap(slot_gap),
        .req(req), .we(we), .am(am), .addr(addr), .wdata(wdata),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rdata(rdata),
        .base_ok(base_ok), .base_addr(base_addr), .module_en(module_en),
        .local_rst(local_rst), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(input string req_tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, exp);
        end
    endtask

    // One access: request during one cycle, result sampled in the response cycle.
    task automatic access(input logic w, input logic [5:0] m, input logic [23:0] a,
                          input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; we = w; am = m; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    function automatic logic [23:0] page(input logic [4:0] s, input logic [18:0] o);
        return {s, o};
    endfunction

    task automatic t_reset;
        check("R9", "rsp_valid", rsp_valid, 0);
        check("R9", "rsp_ack", rsp_ack, 0);
        check("R9", "module_en", module_en, 0);
        check("R9", "local_rst", local_rst, 0);
        check("R2", "base_ok", base_ok, 1);
        check("R2", "base_addr", base_addr, 3);
        @(negedge clk);
        check("R3", "idle no response", rsp_valid, 0);
    endtask

    task automatic t_user_regs;
        access(0, 6'h2F, page(3, 19'h7ff5f), 0);
        check("R7", "vector reset", rdata, 8'h00);
        check("R3", "read ack", rsp_ack, 1);
        access(0, 6'h2F, page(3, 19'h7ff5b), 0);
        check("R7", "level reset", rdata, 8'h00);
        access(1, 6'h2F, page(3, 19'h7ff5f), 8'h5A);
        check("R3", "write valid", rsp_valid, 1);
        check("R7", "irq_vector", irq_vector, 8'h5A);
        access(1, 6'h2F, page(3, 19'h7ff5b), 8'h03);
        access(0, 6'h2F, page(3, 19'h7ff5b), 0);
        check("R7", "level read", rdata, 8'h03);
        check("R7", "irq_level", irq_level, 8'h03);
    endtask

    task automatic t_enable;
        access(1, 6'h2F, page(3, 19'h7fffb), 8'h10);
        check("R5", "enable set", module_en, 1);
        access(0, 6'h2F, page(3, 19'h7fffb), 0);
        check("R5", "set reg read", rdata, 8'h10);
        access(0, 6'h2F, page(3, 19'h7fff7), 0);
        check("R5", "clr reg read", rdata, 8'h10);
        access(1, 6'h2F, page(3, 19'h7fff7), 8'h10);
        check("R5", "enable cleared", module_en, 0);
    endtask

    task automatic t_reset_bit;
        access(1, 6'h2F, page(3, 19'h7fffb), 8'h80);
        check("R6", "reset raised", local_rst, 1);
        access(0, 6'h2F, page(3, 19'h7fffb), 0);
        check("R6", "reset bit read", rdata, 8'h80);
        check("R6", "read keeps reset", local_rst, 1);
        access(1, 6'h2F, page(3, 19'h7ff5f), 8'h5A);
        check("R6", "write clears reset", local_rst, 0);
    endtask

    task automatic t_miss;
        access(1, 6'h39, page(3, 19'h7ff5f), 8'hEE);
        check("R1", "wrong am valid", rsp_valid, 1);
        check("R1", "wrong am ack", rsp_ack, 0);
        access(1, 6'h2F, page(4, 19'h7ff5f), 8'hEE);
        check("R1", "other page ack", rsp_ack, 0);
        check("R1", "vector untouched", irq_vector, 8'h5A);
        access(0, 6'h2F, page(3, 19'h40000), 0);
        check("R4", "unimpl ack", rsp_ack, 1);
        check("R4", "unimpl data", rdata, 8'h00);
    endtask

    task automatic t_rom;
        access(0, 6'h2F, page(3, 19'h0001f), 0);
        check("R8", "sig C", rdata, 8'h43);
        access(0, 6'h2F, page(3, 19'h00023), 0);
        check("R8", "sig R", rdata, 8'h52);
        access(1, 6'h2F, page(3, 19'h00103), 8'h11);
        access(0, 6'h2F, page(3, 19'h00103), 0);
        check("R8", "rom after write", rdata, 8'h40 ^ 8'hA5);
        access(0, 6'h2F, page(3, 19'h00102), 0);
        check("R8", "rom zero lane", rdata, 8'h00);
    endtask

    task automatic t_ga_fault;
        access(1, 6'h2F, page(3, 19'h7fffb), 8'h10);
        check("R5", "enable again", module_en, 1);
        @(negedge clk);
        slot_gap = 1'b0;
        #1;
        check("R2", "parity base_ok", base_ok, 0);
        check("R2", "parity base", base_addr, 0);
        check("R2", "parity module_en", module_en, 0);
        access(0, 6'h2F, page(3, 19'h7ff5f), 0);
        check("R2", "parity no ack", rsp_ack, 0);
        slot_ga = 5'h1f; slot_gap = 1'b0;
        #1;
        check("R2", "pullup base_ok", base_ok, 0);
        access(0, 6'h2F, page(5'h1f, 19'h7ff5f), 0);
        check("R2", "pullup no ack", rsp_ack, 0);
        slot_ga = 5'd3; slot_gap = 1'b1;
        #1;
        check("R2", "restored enable", module_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_user_regs;
        t_enable;
        t_reset_bit;
        t_miss;
        t_rom;
        t_ga_fault;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule